// File: doc/BRIEF.md
# Legacy NMI Status and Control Port

This block is a byte-wide, I/O-mapped register for a PC-compatible platform. It latches two non-maskable-interrupt sources: a system-error pulse from a bus agent and an I/O-check assertion. It combines them into one NMI request, which an external master enable qualifies. A read of the port returns both sticky flags, the live level of timer channel 2's output and a free-running refresh indicator. The indicator flips at the interval at which DRAM refresh would have run. The four low bits are control bits that software can write. They drive the timer channel 2 gate, gate the speaker output, and mask and clear each NMI source.

A sticky flag can be cleared only through its own mask bit. Software writes 1 to the mask bit, which clears and blocks the flag, then writes 0 to re-arm it. The timer, the master NMI enable and the serial interrupt decoder are outside the block and arrive as plain inputs.

Top module: `nmi_port_ctrl`

## Requirements
- R1: After synchronous reset, the port reads 00h when the timer output is low, and `nmi_req`, `spkr_out` and `tmr2_gate` are 0.
- R2: A write with `io_addr` equal to `PORT_ADDR` (default 0061h) loads bits 3:0, and a later read returns them. A write to any other address changes nothing.
- R3: Bits 7:4 of written data are ignored; they read back only their status meaning.
- R4: Bit 7 (system-error flag) sets on any clock edge where `serr_pulse` is high and mask bit 2 is 0, and then stays set.
- R5: Bit 6 (I/O-check flag) sets on any clock edge where `iochk_in` is high and mask bit 3 is 0, and then stays set.
- R6: While a mask bit (2 for bit 7, 3 for bit 6) holds 1, its flag reads 0 and cannot set. Writing the mask back to 0 leaves the flag clear until a new source event arrives.
- R7: A write of 1 to a mask bit in the same cycle as a source event leaves the flag clear.
- R8: Bit 5 reads the current level of `tmr2_out`.
- R9: Bit 4 changes value exactly once every `REFRESH_CYCLES` clock cycles.
- R10: `spkr_out` equals `tmr2_out` when bit 1 is 1 and is 0 when bit 1 is 0.
- R11: `tmr2_gate` equals bit 0.
- R12: `nmi_req` is `nmi_master_en` AND (bit 7 OR bit 6).
- R13: `io_rdata` is 00h unless `io_rd` is high and `io_addr` equals `PORT_ADDR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| serr_pulse | input | 1 | System-error event from a bus agent |
| iochk_in | input | 1 | I/O-check assertion |
| tmr2_out | input | 1 | Timer channel 2 output level |
| nmi_master_en | input | 1 | Master NMI enable from outside the block |
| tmr2_gate | output | 1 | Timer channel 2 gate |
| spkr_out | output | 1 | Gated speaker output |
| nmi_req | output | 1 | Combined NMI request |

## Verification
The bench builds the block with `REFRESH_CYCLES` = 5 and the default port address. With that divide ratio, many refresh periods fit in a short run, so each interval between flips of bit 4 can be measured exactly. The bench writes every one of the 256 data values to the port and checks what reads back. It also crosses every combination of the two flags with the master enable, and every combination of the gating bits with the timer level. The clear-wins collision and the mask-then-unmask sequence are driven on exact cycles.

// File: rtl/nmi_port_pkg.sv
`timescale 1ns/1ps
// Package: shared bit positions and byte type for the NMI status/control port.
// Assumes: bit positions are fixed by software convention and must not move.
package nmi_port_pkg;
    typedef logic [7:0] port_byte_t;

    localparam int unsigned BIT_T2_GATE  = 0;
    localparam int unsigned BIT_SPK_EN   = 1;
    localparam int unsigned BIT_SERR_MSK = 2;
    localparam int unsigned BIT_IOCK_MSK = 3;
    localparam int unsigned BIT_REF_TOG  = 4;
    localparam int unsigned BIT_T2_LVL   = 5;
    localparam int unsigned BIT_IOCK_STS = 6;
    localparam int unsigned BIT_SERR_STS = 7;

    localparam port_byte_t WR_MASK = 8'h0F;
    localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/nmi_src_latch.sv
`timescale 1ns/1ps
// Module: sticky flag for one NMI source.
// Sets on a source event while its mask bit is 0. Clears while the mask holds 1,
// or when the mask is written to 1 this cycle; the clear takes priority.
// Assumes: src_i is synchronous to clk.
module nmi_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic mask_q_i,
    input  logic mask_wr1_i,
    output logic sts_o
);
    logic sts_q;
    logic kill;

    // Clear condition: the stored mask or a mask-set write in progress.
    always_comb kill = mask_q_i | mask_wr1_i;

    // Sticky flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)      sts_q <= 1'b0;
        else if (kill)   sts_q <= 1'b0;
        else if (src_i)  sts_q <= 1'b1;
    end

    assign sts_o = sts_q;

    // R6: a held mask forces the flag clear on the next cycle.
    a_r6_mask_clears: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q_i |=> !sts_o);
    // R7: a mask-set write beats a simultaneous source event.
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr1_i && src_i) |=> !sts_o);
    // R4: a set flag stays set while nothing clears it.
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o && !mask_q_i && !mask_wr1_i) |=> sts_o);
endmodule

// File: rtl/refresh_toggle.sv
`timescale 1ns/1ps
// Module: free-running refresh indicator.
// Flips its output once every PERIOD clock cycles.
// Assumes: PERIOD >= 2.
module refresh_toggle #(
    parameter int unsigned PERIOD = 3000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tog_o
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;
    logic          tog_q;
    logic          wrap;

    // Terminal-count detect.
    always_comb wrap = (cnt_q == LAST);

    // Divider counter and toggle flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            tog_q <= ~tog_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tog_o = tog_q;

    // R9: the output is steady except on the terminal count.
    a_r9_steady_between: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(tog_o));
    // R9: the counter never passes its last value.
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/nmi_port_ctrl.sv
`timescale 1ns/1ps
// Module: byte-wide NMI status and control port (top).
// Decodes reads and writes at PORT_ADDR and holds four control bits.
// Latches two NMI sources, builds the read byte and gates the speaker and timer.
// Assumes: io_wr lasts one cycle per write; read data is combinational.
module nmi_port_ctrl #(
    parameter int unsigned ADDR_W         = 16,
    parameter logic [15:0] PORT_ADDR      = 16'h0061,
    parameter int unsigned REFRESH_CYCLES = 3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              serr_pulse,
    input  logic              iochk_in,
    input  logic              tmr2_out,
    input  logic              nmi_master_en,
    output logic              tmr2_gate,
    output logic              spkr_out,
    output logic              nmi_req
);
    import nmi_port_pkg::*;

    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PORT_ADDR);

    port_byte_t          ctrl_q;
    port_byte_t          rd_val;
    logic                hit;
    logic                ref_tog;
    logic [NUM_SRC-1:0]  src_vec;
    logic [NUM_SRC-1:0]  mask_vec;
    logic [NUM_SRC-1:0]  mask_wr1;
    logic [NUM_SRC-1:0]  sts_vec;

    // Address decode for this port.
    always_comb hit = (io_addr == MY_ADDR);

    // Control byte: only the writable bits load; the upper nibble stays zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            ctrl_q <= '0;
        else if (io_wr && hit) ctrl_q <= (ctrl_q & ~WR_MASK) | (io_wdata & WR_MASK);
    end

    // Per-source wiring: index 0 is system error, index 1 is I/O check.
    always_comb begin
        src_vec  = {iochk_in, serr_pulse};
        mask_vec = {ctrl_q[BIT_IOCK_MSK], ctrl_q[BIT_SERR_MSK]};
        mask_wr1 = {io_wr & hit & io_wdata[BIT_IOCK_MSK],
                    io_wr & hit & io_wdata[BIT_SERR_MSK]};
    end

    // One sticky latch per source.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        nmi_src_latch u_latch (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_i      (src_vec[g]),
            .mask_q_i   (mask_vec[g]),
            .mask_wr1_i (mask_wr1[g]),
            .sts_o      (sts_vec[g])
        );
    end

    refresh_toggle #(.PERIOD(REFRESH_CYCLES)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .tog_o (ref_tog)
    );

    // Read byte assembly: status in the upper nibble, control bits below.
    always_comb begin
        rd_val               = ctrl_q;
        rd_val[BIT_SERR_STS] = sts_vec[0];
        rd_val[BIT_IOCK_STS] = sts_vec[1];
        rd_val[BIT_T2_LVL]   = tmr2_out;
        rd_val[BIT_REF_TOG]  = ref_tog;
    end

    // Read data gating.
    always_comb io_rdata = (io_rd && hit) ? rd_val : 8'h00;

    // Output gating for timer, speaker and NMI request.
    always_comb begin
        tmr2_gate = ctrl_q[BIT_T2_GATE];
        spkr_out  = ctrl_q[BIT_SPK_EN] & tmr2_out;
        nmi_req   = nmi_master_en & (|sts_vec);
    end

    // R12: a request needs the master enable and a set flag.
    a_r12_req_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> (nmi_master_en && (sts_vec != '0)));
    // R10: the speaker is never high while the timer output is low.
    a_r10_spkr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        spkr_out |-> tmr2_out);
    // R13: no read data leaves the block without a read of this port.
    a_r13_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && hit) |-> (io_rdata == 8'h00));
    // R2: the control bits hold when no write hits the port.
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && hit) |=> $stable(ctrl_q));
endmodule

// File: tb/nmi_port_ctrl_test.sv
`timescale 1ns/1ps
module nmi_port_ctrl_test;
    localparam int DIV = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0061;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        serr_pulse = 1'b0, iochk_in = 1'b0, tmr2_out = 1'b0, nmi_master_en = 1'b0;
    logic        tmr2_gate, spkr_out, nmi_req;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    nmi_port_ctrl #(.ADDR_W(16), .PORT_ADDR(16'h0061), .REFRESH_CYCLES(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .serr_pulse(serr_pulse),
        .iochk_in(iochk_in), .tmr2_out(tmr2_out), .nmi_master_en(nmi_master_en),
        .tmr2_gate(tmr2_gate), .spkr_out(spkr_out), .nmi_req(nmi_req));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_addr = 16'h0061;
    endtask

    task automatic rd(output logic [7:0] d);
        io_addr = 16'h0061; io_rd = 1'b1;
        #1;
        d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic pulse(input bit which);
        @(negedge clk);
        if (which) iochk_in = 1'b1; else serr_pulse = 1'b1;
        @(negedge clk);
        iochk_in = 1'b0; serr_pulse = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd(v);
        chk("R1 read", v, 8'h00);
        chk("R1 outs", {nmi_req, spkr_out, tmr2_gate}, 3'b000);
        rst_n = 1'b1;

        // R2/R3: every data value, bit 4 masked, bit 5 equals timer level 0
        for (int i = 0; i < 256; i++) begin
            wr(16'h0061, 8'(i));
            rd(v);
            chk("R2/R3 sweep", v & 8'hEF, 32'(i & 8'h0F));
        end
        // R2: writes elsewhere ignored
        wr(16'h0061, 8'h05);
        wr(16'h0060, 8'h0A); wr(16'h0062, 8'h0A); wr(16'h0161, 8'h0A); wr(16'hE061, 8'h0A);
        rd(v);
        chk("R2 other addr", v & 8'h0F, 8'h05);
        // R13: no read strobe, or other address
        io_addr = 16'h0061; io_rd = 1'b0; #1;
        chk("R13 no strobe", io_rdata, 8'h00);
        io_addr = 16'h0060; io_rd = 1'b1; #1;
        chk("R13 other addr", io_rdata, 8'h00);
        io_rd = 1'b0; io_addr = 16'h0061;

        // R4: system-error flag sets and sticks
        wr(16'h0061, 8'h00);
        pulse(1'b0);
        rd(v);
        chk("R4 set", v & 8'hC0, 8'h80);
        repeat (7) @(negedge clk);
        rd(v);
        chk("R4 sticky", v & 8'hC0, 8'h80);
        // R6: mask clears and blocks, unmask stays clear
        wr(16'h0061, 8'h04);
        rd(v);
        chk("R6 cleared", v[7], 1'b0);
        pulse(1'b0);
        rd(v);
        chk("R6 blocked", v[7], 1'b0);
        wr(16'h0061, 8'h00);
        rd(v);
        chk("R6 unmask clear", v[7], 1'b0);
        pulse(1'b0);
        rd(v);
        chk("R6 rearmed", v[7], 1'b1);

        // R5: I/O-check flag with a held level
        wr(16'h0061, 8'h04);
        @(negedge clk); iochk_in = 1'b1;
        repeat (3) @(negedge clk); iochk_in = 1'b0;
        rd(v);
        chk("R5 set", v & 8'hC0, 8'h40);
        wr(16'h0061, 8'h0C);
        rd(v);
        chk("R5 cleared", v & 8'hC0, 8'h00);
        pulse(1'b1);
        rd(v);
        chk("R5 blocked", v[6], 1'b0);

        // R7: mask write and source event in the same cycle
        wr(16'h0061, 8'h00);
        @(negedge clk);
        serr_pulse = 1'b1; iochk_in = 1'b1; io_wdata = 8'h0C; io_wr = 1'b1;
        @(negedge clk);
        serr_pulse = 1'b0; iochk_in = 1'b0; io_wr = 1'b0;
        rd(v);
        chk("R7 clear wins", v & 8'hC0, 8'h00);
        wr(16'h0061, 8'h00);
        rd(v);
        chk("R7 no pending", v & 8'hC0, 8'h00);

        // R12: every flag combination with the master enable
        for (int c = 0; c < 8; c++) begin
            wr(16'h0061, 8'h0C);
            wr(16'h0061, 8'h00);
            if (c[0]) pulse(1'b0);
            if (c[1]) pulse(1'b1);
            nmi_master_en = c[2];
            #1;
            chk("R12 nmi_req", nmi_req, 32'(c[2] & (c[0] | c[1])));
        end
        nmi_master_en = 1'b0;

        // R8/R10/R11: gating bits crossed with timer level
        for (int c = 0; c < 8; c++) begin
            wr(16'h0061, {6'b0, c[1], c[0]});
            tmr2_out = c[2];
            rd(v);
            chk("R8 level", v[5], c[2]);
            chk("R10 speaker", spkr_out, c[1] & c[2]);
            chk("R11 gate", tmr2_gate, c[0]);
        end
        tmr2_out = 1'b0;

        // R9: interval between flips of bit 4
        begin
            logic prev;
            int   since = 0;
            bit   seen = 1'b0;
            @(negedge clk);
            rd(v); prev = v[4];
            for (int k = 0; k < 8 * DIV; k++) begin
                @(negedge clk);
                rd(v);
                since++;
                if (v[4] != prev) begin
                    if (seen) chk("R9 period", since, DIV);
                    seen = 1'b1; since = 0; prev = v[4];
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule